// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block sequences the operating modes of an on-chip clock generator that is built around a frequency-locked loop. There are four modes: off, self-clocked with the loop open and the controlled oscillator still running, loop engaged on the internal reference, and loop engaged on the external reference. The oscillator, the frequency counter and the analog loop are not part of this block. They appear only as input flags: oscillator stable, reference lost and loop locked.

The self-clocked mode is a gated waypoint between the other modes. When software selects an engaged mode, the block waits in self-clocked mode until the oscillator-stable flag has been qualified, and then it closes the loop by itself. The block also owns the loop-filter register. Software can write this register only while the loop is open. On reset it loads a default that matches the nominal oscillator frequency. When the block falls back from an engaged mode, it keeps the register value so that the frequency is held. If the fall-back comes from external-engaged mode while the loop is unlocked, a doubling flag tells the output divider to double the rate. The reduced-frequency divider setting R is also held here.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: A synchronous active-high reset sets mode_o to 01 (self-clocked), flt_o to the FLT_DEFAULT parameter, rdiv_o to 0 (R = 1) and dbl_o to 0.
- R2: A filter write (flt_wr_i high) that is sampled while mode_o is 01 loads flt_din_i into flt_o at the next edge, and flt_we_o is high for that one cycle.
- R3: A filter write sampled in any other mode (00, 10 or 11) leaves flt_o unchanged, and flt_we_o stays low.
- R4: In mode 01, osc_stable_i must be high on STABLE_CNT consecutive edges (default 2) before the loop closes. A single-cycle stable pulse causes no mode change.
- R5: Once stability is qualified in mode 01, clk_sel_i 01 moves the block to mode 10 and clk_sel_i 11 moves it to mode 11. With clk_sel_i 00 or 10 the block stays in mode 01.
- R6: In mode 11, ref_lost_i forces mode 01 at the next edge, and flt_o is kept.
- R7: In mode 10, changing clk_sel_i to 00 or 10 returns the block to mode 01, keeps flt_o and leaves dbl_o at 0.
- R8: Leaving mode 11 for mode 01 while fll_lock_i is low sets dbl_o. Leaving with fll_lock_i high clears dbl_o. dbl_o is 0 in modes 10 and 11.
- R9: stop_i forces mode 00 from any mode, with priority over every other input. When stop_i is released the block enters mode 01 with flt_o kept.
- R10: rdiv_wr_i loads rdiv_i into rdiv_o at the next edge in every mode.
- R11: In mode 10, clk_sel_i 11 moves the block straight to mode 11. In mode 11, clk_sel_i 01 moves it straight to mode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel_i | input | 2 | Software mode select: 01 internal engaged, 11 external engaged, other values loop open |
| osc_stable_i | input | 1 | Oscillator stable flag |
| ref_lost_i | input | 1 | External reference clock lost |
| fll_lock_i | input | 1 | Loop locked flag |
| stop_i | input | 1 | Request for off mode |
| flt_wr_i | input | 1 | Software write strobe for the filter register |
| flt_din_i | input | FLT_W | Filter write data |
| rdiv_wr_i | input | 1 | Software write strobe for the divider setting |
| rdiv_i | input | DIV_W | Divider setting (log2 R) |
| mode_o | output | 2 | Current mode: 00 off, 01 self-clocked, 10 internal engaged, 11 external engaged |
| flt_o | output | FLT_W | Loop-filter register value |
| flt_we_o | output | 1 | Pulse that marks an accepted filter write |
| rdiv_o | output | DIV_W | Divider setting (log2 R) |
| dbl_o | output | 1 | Output rate doubling request |

## Verification
The bench sends a one-cycle stable pulse to check the qualifier. A design that closed the loop on the first stable sample would jump to an engaged mode there. Filter writes are attempted in each of off, internal-engaged and external-engaged mode. A design that gated writes on the select bits rather than on the mode would corrupt the held frequency. The fall-back from external-engaged mode is run once unlocked and once locked, and the fall-back from internal-engaged mode is run unlocked as well. This catches a doubling flag that ignores the lock state, or one that is raised on the wrong mode. Stop is asserted together with reference loss to check its priority, and a reset in mid-run checks that the default filter value is restored.

// File: rtl/clkgen_mode_pkg.sv
package clkgen_mode_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_SELF = 2'b01,
    MODE_INT  = 2'b10,
    MODE_EXT  = 2'b11
  } cg_mode_e;

  localparam logic [1:0] SEL_INT = 2'b01;
  localparam logic [1:0] SEL_EXT = 2'b11;
endpackage

// File: rtl/cg_stable_qual.sv
module cg_stable_qual #(
  parameter int STABLE_CNT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic stable_i,
  output logic ok_o
);
  localparam int CW = (STABLE_CNT > 1) ? $clog2(STABLE_CNT) : 1;
  localparam logic [CW-1:0] LIM = CW'(STABLE_CNT - 1);

  logic [CW-1:0] cnt_q;

  // count consecutive stable samples while armed, saturating at LIM
  always_ff @(posedge clk) begin
    if (rst || !arm_i || !stable_i) cnt_q <= '0;
    else if (cnt_q < LIM)           cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = arm_i && stable_i && (cnt_q >= LIM);
endmodule

// File: rtl/cg_mode_fsm.sv
module cg_mode_fsm
  import clkgen_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel_i,
  input  logic       stop_i,
  input  logic       lost_i,
  input  logic       lock_i,
  input  logic       qual_i,
  output cg_mode_e   mode_o,
  output logic       dbl_o
);
  cg_mode_e mode_q, mode_d;
  logic     dbl_q, dbl_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_OFF:  if (!stop_i) mode_d = MODE_SELF;
      MODE_SELF: begin
        if (stop_i)                         mode_d = MODE_OFF;
        else if (qual_i && sel_i == SEL_INT) mode_d = MODE_INT;
        else if (qual_i && sel_i == SEL_EXT) mode_d = MODE_EXT;
      end
      MODE_INT: begin
        if (stop_i)                mode_d = MODE_OFF;
        else if (sel_i == SEL_EXT) mode_d = MODE_EXT;
        else if (sel_i != SEL_INT) mode_d = MODE_SELF;
      end
      MODE_EXT: begin
        if (stop_i)                mode_d = MODE_OFF;
        else if (lost_i)           mode_d = MODE_SELF;
        else if (sel_i == SEL_INT) mode_d = MODE_INT;
        else if (sel_i != SEL_EXT) mode_d = MODE_SELF;
      end
      default: mode_d = MODE_SELF;
    endcase
  end

  // doubling: raised only on an unlocked fall-back from external engaged
  always_comb begin
    dbl_d = dbl_q;
    if (mode_d == MODE_INT || mode_d == MODE_EXT)       dbl_d = 1'b0;
    else if (mode_q == MODE_EXT && mode_d == MODE_SELF) dbl_d = !lock_i;
    else if (mode_q == MODE_INT && mode_d == MODE_SELF) dbl_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_SELF;
      dbl_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dbl_q  <= dbl_d;
    end
  end

  assign mode_o = mode_q;
  assign dbl_o  = dbl_q;
endmodule

// File: rtl/cg_filter_reg.sv
module cg_filter_reg #(
  parameter int               W   = 12,
  parameter logic [W-1:0]     DEF = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] q_o,
  output logic         we_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o  <= DEF;
      we_o <= 1'b0;
    end else begin
      we_o <= wr_i;
      if (wr_i) q_o <= din_i;
    end
  end
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
  import clkgen_mode_pkg::*;
#(
  parameter int             FLT_W       = 12,
  parameter logic [FLT_W-1:0] FLT_DEFAULT = 12'h3C5,
  parameter int             DIV_W       = 3,
  parameter int             STABLE_CNT  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       clk_sel_i,
  input  logic             osc_stable_i,
  input  logic             ref_lost_i,
  input  logic             fll_lock_i,
  input  logic             stop_i,
  input  logic             flt_wr_i,
  input  logic [FLT_W-1:0] flt_din_i,
  input  logic             rdiv_wr_i,
  input  logic [DIV_W-1:0] rdiv_i,
  output logic [1:0]       mode_o,
  output logic [FLT_W-1:0] flt_o,
  output logic             flt_we_o,
  output logic [DIV_W-1:0] rdiv_o,
  output logic             dbl_o
);
  cg_mode_e mode;
  logic     in_self, qual, flt_ok;
  logic [DIV_W-1:0] rdiv_q;

  assign in_self = (mode == MODE_SELF);
  assign flt_ok  = flt_wr_i && in_self;

  cg_stable_qual #(.STABLE_CNT(STABLE_CNT)) u_qual (
    .clk(clk), .rst(rst), .arm_i(in_self), .stable_i(osc_stable_i), .ok_o(qual)
  );

  cg_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .sel_i(clk_sel_i), .stop_i(stop_i), .lost_i(ref_lost_i),
    .lock_i(fll_lock_i), .qual_i(qual), .mode_o(mode), .dbl_o(dbl_o)
  );

  cg_filter_reg #(.W(FLT_W), .DEF(FLT_DEFAULT)) u_flt (
    .clk(clk), .rst(rst), .wr_i(flt_ok), .din_i(flt_din_i), .q_o(flt_o), .we_o(flt_we_o)
  );

  always_ff @(posedge clk) begin
    if (rst)            rdiv_q <= '0;
    else if (rdiv_wr_i) rdiv_q <= rdiv_i;
  end

  assign rdiv_o = rdiv_q;
  assign mode_o = mode;
endmodule

// File: rtl/cg_mode_ctrl_chk.sv
module cg_mode_ctrl_chk #(
  parameter int FLT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       clk_sel_i,
  input logic             osc_stable_i,
  input logic             ref_lost_i,
  input logic             fll_lock_i,
  input logic             stop_i,
  input logic             flt_wr_i,
  input logic [FLT_W-1:0] flt_din_i,
  input logic [1:0]       mode_o,
  input logic [FLT_W-1:0] flt_o,
  input logic             flt_we_o,
  input logic             dbl_o
);
  p_we_self_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b01 && flt_wr_i) |=> (flt_we_o && flt_o == $past(flt_din_i)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'b01) |=> ($stable(flt_o) && !flt_we_o));

  p_qual_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b01 && !stop_i && osc_stable_i && !$past(osc_stable_i)) |=> (mode_o == 2'b01));

  p_lost_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b11 && ref_lost_i && !stop_i) |=> (mode_o == 2'b01 && $stable(flt_o)));

  p_dbl_set_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'b11 && ref_lost_i && !stop_i && !fll_lock_i) |=> dbl_o);

  p_dbl_eng_r8: assert property (@(posedge clk) disable iff (rst)
    mode_o[1] |-> !dbl_o);

  p_off_r9: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (mode_o == 2'b00));
endmodule

bind clkgen_mode_ctrl cg_mode_ctrl_chk #(.FLT_W(FLT_W)) u_chk (
  .clk(clk), .rst(rst), .clk_sel_i(clk_sel_i), .osc_stable_i(osc_stable_i),
  .ref_lost_i(ref_lost_i), .fll_lock_i(fll_lock_i), .stop_i(stop_i),
  .flt_wr_i(flt_wr_i), .flt_din_i(flt_din_i), .mode_o(mode_o), .flt_o(flt_o),
  .flt_we_o(flt_we_o), .dbl_o(dbl_o)
);

// File: tb/clkgen_mode_ctrl_tb.sv
module clkgen_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 12;
  localparam int DW = 3;
  localparam logic [FW-1:0] DEF = 12'h3C5;

  typedef struct {
    logic [1:0]    mode;
    logic [FW-1:0] flt;
    logic          we;
    logic [DW-1:0] div;
    logic          dbl;
    string         tag;
  } exp_t;

  logic clk = 0, rst = 1;
  logic [1:0] sel = 2'b00;
  logic stb = 0, loc = 0, lck = 0, stp = 0, fwr = 0, rwr = 0;
  logic [FW-1:0] fd = '0;
  logic [DW-1:0] rd = '0;
  logic [1:0] mode;
  logic [FW-1:0] flt;
  logic we, dbl;
  logic [DW-1:0] div;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_mode_ctrl #(.FLT_W(FW), .FLT_DEFAULT(DEF), .DIV_W(DW), .STABLE_CNT(2)) u_dut (
    .clk(clk), .rst(rst), .clk_sel_i(sel), .osc_stable_i(stb), .ref_lost_i(loc),
    .fll_lock_i(lck), .stop_i(stp), .flt_wr_i(fwr), .flt_din_i(fd),
    .rdiv_wr_i(rwr), .rdiv_i(rd), .mode_o(mode), .flt_o(flt), .flt_we_o(we),
    .rdiv_o(div), .dbl_o(dbl)
  );

  // driver: queue the expected result of the coming edge, then move to the next negedge
  task automatic cyc(input logic [1:0] m, input logic [FW-1:0] f, input logic w,
                     input logic [DW-1:0] d, input logic b, input string tag);
    exp_t e;
    e.mode = m; e.flt = f; e.we = w; e.div = d; e.dbl = b; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compare just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (mode !== e.mode || flt !== e.flt || we !== e.we || div !== e.div || dbl !== e.dbl) begin
          errors++;
          $display("FAIL %s: got mode=%b flt=%h we=%b div=%0d dbl=%b, expected mode=%b flt=%h we=%b div=%0d dbl=%b",
                   e.tag, mode, flt, we, div, dbl, e.mode, e.flt, e.we, e.div, e.dbl);
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(2'b01, DEF, 0, 0, 0, "R1 reset");
    cyc(2'b01, DEF, 0, 0, 0, "R1 reset held");
    rst = 0;
    cyc(2'b01, DEF, 0, 0, 0, "R5 sel 00 stays self");
    fwr = 1; fd = 12'h123;
    cyc(2'b01, 12'h123, 1, 0, 0, "R2 write in self");
    fwr = 0; rwr = 1; rd = 3'd3;
    cyc(2'b01, 12'h123, 0, 3, 0, "R10 divider write");
    rwr = 0; sel = 2'b01; stb = 1;
    cyc(2'b01, 12'h123, 0, 3, 0, "R4 first stable sample");
    stb = 0;
    cyc(2'b01, 12'h123, 0, 3, 0, "R4 single pulse no change");
    stb = 1;
    cyc(2'b01, 12'h123, 0, 3, 0, "R4 first of two");
    cyc(2'b10, 12'h123, 0, 3, 0, "R5 engage internal");
    fwr = 1; fd = 12'h777;
    cyc(2'b10, 12'h123, 0, 3, 0, "R3 write ignored internal");
    fwr = 0; sel = 2'b11;
    cyc(2'b11, 12'h123, 0, 3, 0, "R11 internal to external");
    fwr = 1;
    cyc(2'b11, 12'h123, 0, 3, 0, "R3 write ignored external");
    fwr = 0; sel = 2'b01;
    cyc(2'b10, 12'h123, 0, 3, 0, "R11 external to internal");
    sel = 2'b11;
    cyc(2'b11, 12'h123, 0, 3, 0, "R11 back to external");
    loc = 1; lck = 0;
    cyc(2'b01, 12'h123, 0, 3, 1, "R6 R8 loss unlocked");
    loc = 0; stb = 0; sel = 2'b00; fwr = 1; fd = 12'h456;
    cyc(2'b01, 12'h456, 1, 3, 1, "R2 write after fall-back");
    fwr = 0; sel = 2'b11; stb = 1;
    cyc(2'b01, 12'h456, 0, 3, 1, "R4 qualifying");
    cyc(2'b11, 12'h456, 0, 3, 0, "R8 dbl cleared on engage");
    lck = 1; sel = 2'b00; stb = 0;
    cyc(2'b01, 12'h456, 0, 3, 0, "R8 locked fall-back no double");
    sel = 2'b01; stb = 1;
    cyc(2'b01, 12'h456, 0, 3, 0, "R4 qualifying internal");
    cyc(2'b10, 12'h456, 0, 3, 0, "R5 engage internal again");
    lck = 0; sel = 2'b10; stb = 0;
    cyc(2'b01, 12'h456, 0, 3, 0, "R7 internal to self");
    stp = 1;
    cyc(2'b00, 12'h456, 0, 3, 0, "R9 stop to off");
    fwr = 1; fd = 12'h999;
    cyc(2'b00, 12'h456, 0, 3, 0, "R3 write ignored off");
    fwr = 0; stp = 0;
    cyc(2'b01, 12'h456, 0, 3, 0, "R9 release to self");
    sel = 2'b11; stb = 1;
    cyc(2'b01, 12'h456, 0, 3, 0, "R4 qualifying external");
    cyc(2'b11, 12'h456, 0, 3, 0, "R5 engage external");
    stp = 1; loc = 1;
    cyc(2'b00, 12'h456, 0, 3, 0, "R9 stop beats loss");
    stp = 0; loc = 0; stb = 0;
    cyc(2'b01, 12'h456, 0, 3, 0, "R9 release keeps filter");
    rst = 1;
    cyc(2'b01, DEF, 0, 0, 0, "R1 mid-run reset");
    rst = 0;
    cyc(2'b01, DEF, 0, 0, 0, "R1 after reset");
    @(posedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule